// File: doc/BRIEF.md
# AXI4-Lite Shared Byte Memory

This block is a small memory reached from two sides. One side is an AXI4-Lite slave with 32-bit data, separate address, data and response channels for writes, and a separate read channel. The other side is a byte-wide port for an 8-bit controller. The controller loads a byte address into an address register and then sees the byte at that address on its read-data output. It writes by pulsing a write strobe together with a data byte. The byte is stored at the address currently held in the register.

A 32-bit word is stored little-endian. Its least significant byte sits at the lowest byte address of the word, and its most significant byte at the highest. The size `MEM_BYTES` is a power of two from 16 to 256 and defaults to 256. Both address inputs and the controller address are log2(`MEM_BYTES`) bits wide. `WIDE_RAM` chooses the storage layout: a byte-wide array (0, the default) or a 32-bit array with byte enables (1). Both layouts behave the same. One clock `clk_i` and the active-low asynchronous reset `rst_ni` serve both sides.

Top module: `axil_byte_mem`

## Requirements
- R1: All of `MEM_BYTES` bytes can be addressed, including the word at the top address `MEM_BYTES`-4 and its last byte `MEM_BYTES`-1.
- R2: A word written over AXI places wdata[7:0] at byte address 4k, [15:8] at 4k+1, [23:16] at 4k+2 and [31:24] at 4k+3. An AXI read assembles the word in the same order.
- R3: Write strobe bit i enables byte lane i (wdata[8i+7:8i]). A lane whose strobe bit is 0 keeps its previous contents.
- R4: The address register loads `mc_addr_i` on a clock edge where `mc_addr_load_i` is 1. From the next cycle on, `mc_rdata_o` shows the byte at that address.
- R5: A clock edge with `mc_wr_i` = 1 stores `mc_wdata_i` at the address in the register. The new byte is visible on `mc_rdata_o` and on AXI reads afterwards.
- R6: Address and data can arrive on different cycles. `bvalid_o` rises only in the cycle after both have been accepted. Each channel accepts one item and then holds its ready low until the response completes.
- R7: `bvalid_o` stays high until a clock edge with `bready_i` = 1, and `bresp_o` is 00 (OKAY) while it is high.
- R8: `rvalid_o` rises in the cycle after an accepted read address. It then stays high with stable `rdata_o` until a clock edge with `rready_i` = 1. `rresp_o` is 00, and `arready_o` is low while `rvalid_o` is high.
- R9: The two low AXI address bits are ignored. Addresses 4k to 4k+3 select the same word.
- R10: If the controller and an enabled AXI lane write the same byte at the same edge, the controller's byte is stored.
- R11: A read in the same cycle as a write to the same location returns the contents from before that write. This holds for the AXI read channel and for `mc_rdata_o`.
- R12: After reset, `bvalid_o` and `rvalid_o` are 0, and `awready_o`, `wready_o` and `arready_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| awaddr_i | input | AW | Write byte address |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte lane enables |
| bresp_o | output | 2 | Write response, always OKAY |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| araddr_i | input | AW | Read byte address |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response, always OKAY |
| mc_addr_load_i | input | 1 | Load controller address register |
| mc_addr_i | input | AW | Controller byte address |
| mc_wr_i | input | 1 | Controller write strobe |
| mc_wdata_i | input | 8 | Controller write byte |
| mc_rdata_o | output | 8 | Byte at the controller address |

## Verification
Each result has a fixed due time. `bvalid_o` is due one cycle after the edge at which the later of the address and data beats is accepted. `rvalid_o` and `rdata_o` are due one cycle after the read address edge. `mc_rdata_o` is due one cycle after the address load or write strobe. The bench drives and samples only on falling edges, so every check reads the value one register stage after the edge that caused it. For the held-response and same-cycle cases, the bench checks the result at each falling edge while the ready input stays low.

// File: rtl/axil_mem_pkg.sv
package axil_mem_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic        en;
    logic [3:0]  strb;
    logic [31:0] data;
  } word_wr_t;
endpackage

// File: rtl/axil_wr_chan.sv
module axil_wr_chan
  import axil_mem_pkg::*;
#(
  parameter int AW = 8,
  localparam int WW = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          awvalid_i,
  output logic          awready_o,
  input  logic [AW-1:0] awaddr_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    wstrb_i,
  output logic          bvalid_o,
  input  logic          bready_i,
  output word_wr_t      wr_o,
  output logic [WW-1:0] wr_word_o
);
  logic          aw_hold_q, w_hold_q, bvalid_q;
  logic [WW-1:0] aw_word_q;
  logic [31:0]   wdata_q;
  logic [3:0]    wstrb_q;
  logic          aw_fire, w_fire, commit;

  assign awready_o = !aw_hold_q && !bvalid_q;
  assign wready_o  = !w_hold_q && !bvalid_q;
  assign aw_fire   = awvalid_i && awready_o;
  assign w_fire    = wvalid_i && wready_o;
  assign commit    = (aw_hold_q || aw_fire) && (w_hold_q || w_fire);

  assign wr_word_o = aw_hold_q ? aw_word_q : awaddr_i[AW-1:2];
  assign wr_o.en   = commit;
  assign wr_o.data = w_hold_q ? wdata_q : wdata_i;
  assign wr_o.strb = w_hold_q ? wstrb_q : wstrb_i;
  assign bvalid_o  = bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_hold_q <= 1'b0;
      w_hold_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_word_q <= '0;
      wdata_q   <= '0;
      wstrb_q   <= '0;
    end else begin
      if (commit) begin
        aw_hold_q <= 1'b0;
        w_hold_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else begin
        if (aw_fire) begin
          aw_hold_q <= 1'b1;
          aw_word_q <= awaddr_i[AW-1:2];
        end
        if (w_fire) begin
          w_hold_q <= 1'b1;
          wdata_q  <= wdata_i;
          wstrb_q  <= wstrb_i;
        end
        if (bvalid_q && bready_i) bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_rd_chan.sv
module axil_rd_chan #(
  parameter int AW = 8,
  localparam int WW = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arvalid_i,
  output logic          arready_o,
  input  logic [AW-1:0] araddr_i,
  output logic          rvalid_o,
  input  logic          rready_i,
  output logic [31:0]   rdata_o,
  output logic [WW-1:0] rd_word_o,
  input  logic [31:0]   rd_word_data_i
);
  logic        rvalid_q;
  logic [31:0] rdata_q;

  assign arready_o = !rvalid_q;
  assign rd_word_o = araddr_i[AW-1:2];
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_byte_store.sv
module mem_byte_store
  import axil_mem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter bit WIDE_RAM  = 1'b0,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int WW    = AW - 2,
  localparam int WORDS = MEM_BYTES / 4
) (
  input  logic          clk_i,
  input  word_wr_t      axi_wr_i,
  input  logic [WW-1:0] axi_wr_word_i,
  input  logic [WW-1:0] axi_rd_word_i,
  output logic [31:0]   axi_rd_data_o,
  input  logic          mc_we_i,
  input  logic [AW-1:0] mc_addr_i,
  input  logic [7:0]    mc_wdata_i,
  output logic [7:0]    mc_rdata_o
);
  // controller write is applied after the AXI lanes, so it wins on overlap
  if (WIDE_RAM) begin : g_word
    logic [31:0] mem32 [WORDS];
    always_ff @(posedge clk_i) begin
      for (int l = 0; l < 4; l++)
        if (axi_wr_i.en && axi_wr_i.strb[l])
          mem32[axi_wr_word_i][8*l +: 8] <= axi_wr_i.data[8*l +: 8];
      if (mc_we_i)
        mem32[mc_addr_i[AW-1:2]][8*mc_addr_i[1:0] +: 8] <= mc_wdata_i;
    end
    assign axi_rd_data_o = mem32[axi_rd_word_i];
    assign mc_rdata_o    = mem32[mc_addr_i[AW-1:2]][8*mc_addr_i[1:0] +: 8];
  end else begin : g_byte
    logic [7:0] mem8 [MEM_BYTES];
    always_ff @(posedge clk_i) begin
      for (int l = 0; l < 4; l++)
        if (axi_wr_i.en && axi_wr_i.strb[l])
          mem8[{axi_wr_word_i, 2'(l)}] <= axi_wr_i.data[8*l +: 8];
      if (mc_we_i)
        mem8[mc_addr_i] <= mc_wdata_i;
    end
    for (genvar l = 0; l < 4; l++) begin : g_lane
      assign axi_rd_data_o[8*l +: 8] = mem8[{axi_rd_word_i, 2'(l)}];
    end
    assign mc_rdata_o = mem8[mc_addr_i];
  end
endmodule

// File: rtl/axil_byte_mem.sv
module axil_byte_mem
  import axil_mem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter bit WIDE_RAM  = 1'b0,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int WW = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          awvalid_i,
  output logic          awready_o,
  input  logic [AW-1:0] awaddr_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    wstrb_i,
  output logic [1:0]    bresp_o,
  output logic          bvalid_o,
  input  logic          bready_i,
  input  logic          arvalid_i,
  output logic          arready_o,
  input  logic [AW-1:0] araddr_i,
  output logic          rvalid_o,
  input  logic          rready_i,
  output logic [31:0]   rdata_o,
  output logic [1:0]    rresp_o,
  input  logic          mc_addr_load_i,
  input  logic [AW-1:0] mc_addr_i,
  input  logic          mc_wr_i,
  input  logic [7:0]    mc_wdata_i,
  output logic [7:0]    mc_rdata_o
);
  word_wr_t      axi_wr;
  logic [WW-1:0] axi_wr_word, axi_rd_word;
  logic [31:0]   axi_rd_data;
  logic [AW-1:0] mc_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mc_addr_q <= '0;
    else if (mc_addr_load_i) mc_addr_q <= mc_addr_i;
  end

  assign bresp_o = RESP_OKAY;
  assign rresp_o = RESP_OKAY;

  axil_wr_chan #(.AW(AW)) u_wr (
    .clk_i, .rst_ni,
    .awvalid_i, .awready_o, .awaddr_i,
    .wvalid_i, .wready_o, .wdata_i, .wstrb_i,
    .bvalid_o, .bready_i,
    .wr_o      (axi_wr),
    .wr_word_o (axi_wr_word)
  );

  axil_rd_chan #(.AW(AW)) u_rd (
    .clk_i, .rst_ni,
    .arvalid_i, .arready_o, .araddr_i,
    .rvalid_o, .rready_i, .rdata_o,
    .rd_word_o      (axi_rd_word),
    .rd_word_data_i (axi_rd_data)
  );

  mem_byte_store #(.MEM_BYTES(MEM_BYTES), .WIDE_RAM(WIDE_RAM)) u_mem (
    .clk_i,
    .axi_wr_i      (axi_wr),
    .axi_wr_word_i (axi_wr_word),
    .axi_rd_word_i (axi_rd_word),
    .axi_rd_data_o (axi_rd_data),
    .mc_we_i       (mc_wr_i),
    .mc_addr_i     (mc_addr_q),
    .mc_wdata_i    (mc_wdata_i),
    .mc_rdata_o    (mc_rdata_o)
  );
endmodule

// File: rtl/axil_byte_mem_chk.sv
module axil_byte_mem_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        awready_o,
  input logic        wready_o,
  input logic        bvalid_o,
  input logic        bready_i,
  input logic        arready_o,
  input logic        rvalid_o,
  input logic        rready_i,
  input logic [31:0] rdata_o
);
  // R7
  bvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);
  // R6
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> !awready_o && !wready_o);
  // R8
  rvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
  // R8
  rd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !arready_o);
endmodule

bind axil_byte_mem axil_byte_mem_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .awready_o (awready_o),
  .wready_o  (wready_o),
  .bvalid_o  (bvalid_o),
  .bready_i  (bready_i),
  .arready_o (arready_o),
  .rvalid_o  (rvalid_o),
  .rready_i  (rready_i),
  .rdata_o   (rdata_o)
);

// File: tb/axil_byte_mem_test.sv
module axil_byte_mem_test;
  localparam int MEM_BYTES = 256;
  localparam int AW = $clog2(MEM_BYTES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [AW-1:0] awaddr = '0, araddr = '0, mc_addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic mc_load = 0, mc_wr = 0;
  logic [7:0] mc_wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [7:0] mc_rdata;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  axil_byte_mem #(.MEM_BYTES(MEM_BYTES)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .awvalid_i(awvalid), .awready_o(awready), .awaddr_i(awaddr),
    .wvalid_i(wvalid), .wready_o(wready), .wdata_i(wdata), .wstrb_i(wstrb),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .arvalid_i(arvalid), .arready_o(arready), .araddr_i(araddr),
    .rvalid_o(rvalid), .rready_i(rready), .rdata_o(rdata), .rresp_o(rresp),
    .mc_addr_load_i(mc_load), .mc_addr_i(mc_addr), .mc_wr_i(mc_wr),
    .mc_wdata_i(mc_wdata), .mc_rdata_o(mc_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic b_finish(input string req, input int hold);
    for (int i = 0; i < hold; i++) begin
      step();
      chk("R7 bvalid held", 32'(bvalid), 1);
      chk("R7 bresp", 32'(bresp), 0);
    end
    bready = 1; step(); bready = 0;
    chk(req, 32'(bvalid), 0);
  endtask

  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] s, input int hold, input string req);
    @(negedge clk);
    awvalid = 1; awaddr = a; wvalid = 1; wdata = d; wstrb = s;
    step();
    awvalid = 0; wvalid = 0;
    chk(req, 32'(bvalid), 1);
    b_finish(req, hold);
  endtask

  task automatic axi_read(input logic [AW-1:0] a, input logic [31:0] exp,
                          input int hold, input string req);
    @(negedge clk);
    arvalid = 1; araddr = a;
    step();
    arvalid = 0;
    chk(req, 32'(rvalid), 1);
    chk(req, rdata, exp);
    for (int i = 0; i < hold; i++) begin
      step();
      chk("R8 rvalid held", 32'(rvalid), 1);
      chk("R8 rdata stable", rdata, exp);
      chk("R8 rresp", 32'(rresp), 0);
      chk("R8 arready low", 32'(arready), 0);
    end
    rready = 1; step(); rready = 0;
    chk("R8 rvalid drop", 32'(rvalid), 0);
  endtask

  task automatic mc_set(input logic [AW-1:0] a);
    @(negedge clk);
    mc_load = 1; mc_addr = a;
    step();
    mc_load = 0;
  endtask

  task automatic mc_put(input logic [7:0] d);
    @(negedge clk);
    mc_wr = 1; mc_wdata = d;
    step();
    mc_wr = 0;
  endtask

  task automatic t_reset();
    chk("R12 awready", 32'(awready), 1);
    chk("R12 wready", 32'(wready), 1);
    chk("R12 arready", 32'(arready), 1);
    chk("R12 bvalid", 32'(bvalid), 0);
    chk("R12 rvalid", 32'(rvalid), 0);
  endtask

  task automatic t_endian();
    axi_write(8'h00, 32'h44332211, 4'hF, 0, "R2 write");
    for (int b = 0; b < 4; b++) begin
      mc_set(AW'(b));
      chk("R2 R4 byte", 32'(mc_rdata), 32'(8'h11 * (b + 1)));
    end
    axi_read(8'h00, 32'h44332211, 0, "R2 read");
  endtask

  task automatic t_strobe();
    axi_write(8'h00, 32'hAABBCCDD, 4'b0101, 0, "R3 write");
    axi_read(8'h00, 32'h44BB22DD, 0, "R3 lanes");
  endtask

  task automatic t_mc_write();
    axi_write(8'h04, 32'h89ABCDEF, 4'hF, 0, "R5 init");
    mc_set(8'h05);
    chk("R4 addr", 32'(mc_rdata), 32'hCD);
    mc_put(8'h77);
    chk("R5 mc view", 32'(mc_rdata), 32'h77);
    axi_read(8'h04, 32'h89AB77EF, 0, "R5 axi view");
  endtask

  task automatic t_split();
    @(negedge clk);
    awvalid = 1; awaddr = 8'h08;
    step();
    awvalid = 0;
    chk("R6 no early bvalid", 32'(bvalid), 0);
    chk("R6 awready held low", 32'(awready), 0);
    chk("R6 wready open", 32'(wready), 1);
    step();
    chk("R6 still waiting", 32'(bvalid), 0);
    wvalid = 1; wdata = 32'h11112222; wstrb = 4'hF;
    step();
    wvalid = 0;
    chk("R6 bvalid after both", 32'(bvalid), 1);
    b_finish("R7 bvalid drop", 3);
    axi_read(8'h08, 32'h11112222, 3, "R8 read");
  endtask

  task automatic t_lowbits();
    axi_write(8'h13, 32'hCAFEF00D, 4'hF, 0, "R9 write");
    axi_read(8'h10, 32'hCAFEF00D, 0, "R9 read aligned");
    axi_read(8'h12, 32'hCAFEF00D, 0, "R9 read offset");
    mc_set(8'h10);
    chk("R9 byte", 32'(mc_rdata), 32'h0D);
  endtask

  task automatic t_collide();
    mc_set(8'h18);
    @(negedge clk);
    awvalid = 1; awaddr = 8'h18; wvalid = 1; wdata = 32'hAABBCCDD; wstrb = 4'hF;
    mc_wr = 1; mc_wdata = 8'h5A;
    step();
    awvalid = 0; wvalid = 0; mc_wr = 0;
    chk("R10 mc wins", 32'(mc_rdata), 32'h5A);
    b_finish("R10 resp", 0);
    axi_read(8'h18, 32'hAABBCC5A, 0, "R10 word");
  endtask

  task automatic t_rd_old();
    axi_write(8'h14, 32'h01020304, 4'hF, 0, "R11 init");
    mc_set(8'h14);
    @(negedge clk);
    awvalid = 1; awaddr = 8'h14; wvalid = 1; wdata = 32'hFFFFFFFF; wstrb = 4'hF;
    arvalid = 1; araddr = 8'h14;
    #1 chk("R11 mc old", 32'(mc_rdata), 32'h04);
    step();
    awvalid = 0; wvalid = 0; arvalid = 0;
    chk("R11 axi old", rdata, 32'h01020304);
    chk("R11 mc new", 32'(mc_rdata), 32'hFF);
    b_finish("R11 resp", 0);
    rready = 1; step(); rready = 0;
  endtask

  task automatic t_top();
    axi_write(AW'(MEM_BYTES - 4), 32'hDEADBEEF, 4'hF, 0, "R1 write");
    axi_read(AW'(MEM_BYTES - 4), 32'hDEADBEEF, 0, "R1 read");
    mc_set(AW'(MEM_BYTES - 1));
    chk("R1 top byte", 32'(mc_rdata), 32'hDE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_endian();
    t_strobe();
    t_mc_write();
    t_split();
    t_lowbits();
    t_collide();
    t_rd_old();
    t_top();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule